// File: doc/BRIEF.md
# Buffered SPI Port with Selectable Interrupt

This block is an 8-bit SPI port with a four-entry FIFO on each side. Software pushes words into the transmit FIFO with a write strobe. It pops received words from the receive FIFO with a read strobe, and the oldest received word is always visible on the read-data port. A single status byte reports how full each FIFO is, whether the shifter is busy, whether a received word was lost, and an element count. That count reports pending transmit words when the port drives the bus and unread received words when it follows an external bus driver. One interrupt line is a level. A 3-bit mode field picks which of eight FIFO or shifter conditions drives it.

The shifter is a state machine with five states. ST_IDLE waits for work. ST_M_LOW and ST_M_HIGH are the two clock phases of a word driven by this port. ST_S_ACT follows an external clock while the select input is low. ST_FIN delivers the completed word to the receive FIFO.

The transitions are as follows:
- ST_IDLE moves to ST_M_LOW in master mode when the transmit FIFO is not empty.
- ST_IDLE moves to ST_S_ACT in slave mode when the select input is low.
- ST_M_LOW moves to ST_M_HIGH after DIV cycles.
- ST_M_HIGH moves back to ST_M_LOW after DIV cycles, or to ST_FIN after the eighth bit.
- ST_S_ACT moves to ST_FIN on the eighth rising clock.
- ST_S_ACT moves to ST_IDLE when the select input goes high.
- ST_FIN moves to ST_IDLE.
- A low enable forces ST_IDLE.

Both SPI modes use clock-idle-low timing: data is sampled on the rising edge and changed on the falling edge.

Top module: `spi_buf_ctrl`

## Requirements
- R1: While `en` is low, `sck_o` is 0, `ss_n_o` is 1 and `sdo_o` is 0. Both FIFOs are held empty, `tx_wr` is ignored and the shifter is idle.
- R2: In master mode (`master`=1), a word starts whenever the transmit FIFO holds data and the shifter is idle. For the whole word `ss_n_o` is low. `sck_o` idles low and spends DIV (4) cycles in each phase. `sdo_o` presents the word MSB first and is stable while `sck_o` is high. `sdi_i` is sampled at each rise, and the 8 sampled bits form the received word.
- R3: In slave mode, a falling `ss_n_i` loads the oldest transmit word, or 0x00 if the transmit FIFO is empty. After each completed word the next one is loaded while `ss_n_i` stays low. `sdo_o` shifts MSB first and changes after falling `sck_i` edges. `sdi_i` is sampled at rising `sck_i` edges, and the word is delivered after the eighth rise.
- R4: `status[2:0]` is the transmit FIFO count in master mode and the receive FIFO count in slave mode.
- R5: `status[3]` is 1 exactly when the shifter is idle. Taking a transmit word makes it 0 in the next cycle.
- R6: `status[4]` is the overflow flag. It is set when a word completes while the receive FIFO is full, and that word is discarded. The flag holds until a pulse on `ovf_clr`, and setting wins over clearing.
- R7: `status[5]` is receive-FIFO-empty, `status[6]` is transmit-FIFO-full and `status[7]` is receive-FIFO-full.
- R8: `irq` is a level chosen by `imode`, with depth 4:
  - 7: transmit FIFO full.
  - 6: transmit FIFO empty.
  - 5: transmit FIFO empty and shifter idle.
  - 4: transmit FIFO not full.
  - 3: receive FIFO full.
  - 2: receive count at least 3.
  - 1: receive FIFO not empty.
  - 0: receive FIFO empty.
- R9: A `tx_wr` into a full transmit FIFO and an `rx_rd` from an empty receive FIFO have no effect. `rx_data` shows the oldest unread word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable |
| master | input | 1 | 1 drives the bus, 0 follows it |
| imode | input | 3 | Interrupt condition select |
| tx_wr | input | 1 | Push `tx_data` into transmit FIFO |
| tx_data | input | 8 | Transmit word |
| rx_rd | input | 1 | Pop the receive FIFO |
| rx_data | output | 8 | Oldest received word |
| ovf_clr | input | 1 | Clears the overflow flag |
| status | output | 8 | Status byte (see R4 to R7) |
| irq | output | 1 | Selected interrupt level |
| sck_i | input | 1 | External serial clock (slave) |
| ss_n_i | input | 1 | External select, active low (slave) |
| sdi_i | input | 1 | Serial data in |
| sck_o | output | 1 | Generated serial clock (master) |
| ss_n_o | output | 1 | Generated select, active low (master) |
| sdo_o | output | 1 | Serial data out |

## Verification
The hardest condition to reach from the ports is a receive overflow at the same time as an exhausted transmit FIFO inside one slave frame. The bench fills the transmit FIFO past its depth, then runs a single select-low frame of five words without reading. The fifth word must both shift out as 0x00 and be discarded with the overflow flag set. Master-mode traffic runs with the data output looped back to the data input, so every transmitted word returns as a received word that the model can predict. Random mixes of master bursts, slave frames, partial reads and flag clears then sweep all eight interrupt modes at many FIFO levels.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_M_LOW,
        ST_M_HIGH,
        ST_S_ACT,
        ST_FIN
    } eng_state_t;

    localparam int unsigned IMODE_W = 3;
    localparam int unsigned STAT_W  = 8;
endpackage

// File: rtl/spi_buf_fifo.sv
// Synchronous FIFO; DEPTH must be a power of two so pointers wrap naturally.
module spi_buf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    p_full_push_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/spi_buf_engine.sv
module spi_buf_engine import spi_buf_pkg::*; #(
    parameter int W   = 8,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         master,
    input  logic         tx_empty,
    input  logic [W-1:0] tx_head,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    output logic         sr_empty,
    input  logic         sck_i,
    input  logic         ss_n_i,
    input  logic         sdi_i,
    output logic         sck_o,
    output logic         ss_n_o,
    output logic         sdo_o
);
    localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BCW = $clog2(W);
    localparam logic [2:0] SYNC_RST = 3'b010;

    eng_state_t     state;
    logic [W-1:0]   shreg, rxsh;
    logic [BCW-1:0] bitcnt;
    logic [DCW-1:0] divcnt;
    logic [2:0]     raw_in, sync_a, sync_b;
    logic           sck_p, sck_s, ss_s, sdi_s, sck_rise, sck_fall;
    logic           div_end, bit_last;

    assign raw_in = {sck_i, ss_n_i, sdi_i};
    for (genvar g = 0; g < 3; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_a[g] <= SYNC_RST[g];
                sync_b[g] <= SYNC_RST[g];
            end else begin
                sync_a[g] <= raw_in[g];
                sync_b[g] <= sync_a[g];
            end
        end
    end

    assign sck_s    = sync_b[2];
    assign ss_s     = sync_b[1];
    assign sdi_s    = sync_b[0];
    assign sck_rise = sck_s && !sck_p;
    assign sck_fall = !sck_s && sck_p;
    assign div_end  = (divcnt == DCW'(DIV - 1));
    assign bit_last = (bitcnt == BCW'(W - 1));

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            rxsh   <= '0;
            bitcnt <= '0;
            divcnt <= '0;
            sck_p  <= 1'b0;
        end else begin
            sck_p <= sck_s;
            if (!en) begin
                state  <= ST_IDLE;
                bitcnt <= '0;
                divcnt <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        bitcnt <= '0;
                        divcnt <= '0;
                        if (master && !tx_empty) begin
                            shreg <= tx_head;
                            state <= ST_M_LOW;
                        end else if (!master && !ss_s) begin
                            shreg <= tx_empty ? '0 : tx_head;
                            state <= ST_S_ACT;
                        end
                    end
                    ST_M_LOW: begin
                        if (div_end) begin
                            divcnt <= '0;
                            rxsh   <= {rxsh[W-2:0], sdi_s};
                            state  <= ST_M_HIGH;
                        end else divcnt <= divcnt + 1'b1;
                    end
                    ST_M_HIGH: begin
                        if (div_end) begin
                            divcnt <= '0;
                            if (bit_last) state <= ST_FIN;
                            else begin
                                bitcnt <= bitcnt + 1'b1;
                                shreg  <= {shreg[W-2:0], 1'b0};
                                state  <= ST_M_LOW;
                            end
                        end else divcnt <= divcnt + 1'b1;
                    end
                    ST_S_ACT: begin
                        if (ss_s) state <= ST_IDLE;
                        else if (sck_rise) begin
                            rxsh <= {rxsh[W-2:0], sdi_s};
                            if (bit_last) state <= ST_FIN;
                            else bitcnt <= bitcnt + 1'b1;
                        end else if (sck_fall && bitcnt != '0) begin
                            shreg <= {shreg[W-2:0], 1'b0};
                        end
                    end
                    ST_FIN:  state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        sck_o    = (state == ST_M_HIGH);
        ss_n_o   = !((state == ST_M_LOW) || (state == ST_M_HIGH));
        sdo_o    = ((state == ST_M_LOW) || (state == ST_M_HIGH) || (state == ST_S_ACT))
                   ? shreg[W-1] : 1'b0;
        tx_pop   = (state == ST_IDLE) && en && !tx_empty && (master || !ss_s);
        rx_push  = (state == ST_FIN);
        rx_word  = rxsh;
        sr_empty = (state == ST_IDLE);
    end

    p_disabled_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sr_empty && ss_n_o && !sck_o && !sdo_o));
    p_master_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_M_HIGH && $past(state) == ST_M_HIGH) |-> $stable(sdo_o));
    p_pop_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !sr_empty);
endmodule

// File: rtl/spi_buf_ctrl.sv
module spi_buf_ctrl import spi_buf_pkg::*; #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int DIV   = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               master,
    input  logic [IMODE_W-1:0] imode,
    input  logic               tx_wr,
    input  logic [W-1:0]       tx_data,
    input  logic               rx_rd,
    output logic [W-1:0]       rx_data,
    input  logic               ovf_clr,
    output logic [STAT_W-1:0]  status,
    output logic               irq,
    input  logic               sck_i,
    input  logic               ss_n_i,
    input  logic               sdi_i,
    output logic               sck_o,
    output logic               ss_n_o,
    output logic               sdo_o
);
    logic [W-1:0]  tx_head, rx_word;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          tx_pop, rx_push, sr_empty, rx_ovf, three_q;

    spi_buf_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!en), .push(tx_wr), .din(tx_data),
        .pop(tx_pop), .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    spi_buf_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!en), .push(rx_push && en), .din(rx_word),
        .pop(rx_rd), .head(rx_data), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    spi_buf_engine #(.W(W), .DIV(DIV)) u_engine (
        .clk(clk), .rst_n(rst_n), .en(en), .master(master),
        .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word), .sr_empty(sr_empty),
        .sck_i(sck_i), .ss_n_i(ss_n_i), .sdi_i(sdi_i),
        .sck_o(sck_o), .ss_n_o(ss_n_o), .sdo_o(sdo_o));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        rx_ovf <= 1'b0;
        else if (rx_push && en && rx_full) rx_ovf <= 1'b1;
        else if (ovf_clr)                  rx_ovf <= 1'b0;
    end

    assign three_q = (int'(rx_cnt) * 4) >= (DEPTH * 3);

    always_comb begin
        unique case (imode)
            3'b111: irq = tx_full;
            3'b110: irq = tx_empty;
            3'b101: irq = tx_empty && sr_empty;
            3'b100: irq = !tx_full;
            3'b011: irq = rx_full;
            3'b010: irq = three_q;
            3'b001: irq = !rx_empty;
            3'b000: irq = rx_empty;
            default: irq = 1'b0;
        endcase
    end

    assign status = {rx_full, tx_full, rx_empty, rx_ovf, sr_empty,
                     master ? 3'(tx_cnt) : 3'(rx_cnt)};

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf && !ovf_clr) |=> rx_ovf);
    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && en && rx_full) |=> rx_ovf);
    p_irq_txfull_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (imode == 3'b111 && tx_full) |-> irq);
endmodule

// File: tb/spi_buf_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_buf_ctrl_tb_top;
    localparam int DEPTH = 4;
    localparam int DIV   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       en = 1'b0, master = 1'b1, tx_wr = 1'b0, rx_rd = 1'b0, ovf_clr = 1'b0;
    logic [2:0] imode = 3'd0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data, status;
    logic       irq, sck_o, ss_n_o, sdo_o, sdi_i;
    logic       sck_i = 1'b0, ss_n_i = 1'b1, tb_sdi = 1'b0;

    assign sdi_i = master ? sdo_o : tb_sdi;

    spi_buf_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .master(master), .imode(imode),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .ovf_clr(ovf_clr), .status(status), .irq(irq),
        .sck_i(sck_i), .ss_n_i(ss_n_i), .sdi_i(sdi_i),
        .sck_o(sck_o), .ss_n_o(ss_n_o), .sdo_o(sdo_o));

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;
    logic [7:0] rxq[$];
    logic       ovf_m = 1'b0;
    logic [7:0] mo_a[8], mi_a[8], txw[8];

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat(input logic m, input int txc, input int rxc,
                                            input logic sre, input logic ov);
        logic [2:0] c;
        c = m ? 3'(txc) : 3'(rxc);
        return {rxc == DEPTH, txc == DEPTH, rxc == 0, ov, sre, c};
    endfunction

    function automatic logic exp_irq(input int md, input int txc, input int rxc, input logic sre);
        case (md)
            7: return txc == DEPTH;
            6: return txc == 0;
            5: return (txc == 0) && sre;
            4: return txc < DEPTH;
            3: return rxc == DEPTH;
            2: return rxc * 4 >= DEPTH * 3;
            1: return rxc > 0;
            default: return rxc == 0;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_tx(input logic [7:0] d);
        tx_data = d; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
    endtask

    task automatic rd_rx(output logic [7:0] d);
        d = rx_data; rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
    endtask

    task automatic model_push(input logic [7:0] d);
        if (rxq.size() < DEPTH) rxq.push_back(d);
        else ovf_m = 1'b1;
    endtask

    task automatic wait_idle();
        int n = 0;
        tick(2);
        while (!(status[3] && status[2:0] == 3'd0) && n < 3000) begin
            tick(1); n++;
        end
    endtask

    task automatic check_irq_all(input int txc, input int rxc, input logic sre);
        for (int m = 0; m < 8; m++) begin
            imode = 3'(m);
            tick(1);
            chk("R8 irq mode", {29'd0, imode}, 32'(m));
            chk("R8 irq level", {31'd0, irq}, {31'd0, exp_irq(m, txc, rxc, sre)});
        end
        imode = 3'd0;
    endtask

    // One slave frame of n words, select held low throughout
    task automatic slv_frame(input int n);
        ss_n_i = 1'b0;
        tick(8);
        for (int w = 0; w < n; w++) begin
            for (int i = 7; i >= 0; i--) begin
                tb_sdi = mo_a[w][i];
                tick(8);
                mi_a[w][i] = sdo_o;
                sck_i = 1'b1;
                tick(8);
                sck_i = 1'b0;
            end
        end
        tick(8);
        ss_n_i = 1'b1;
        tick(8);
    endtask

    initial begin : watchdog
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        logic [7:0] d, got;
        int hi_cnt, rises, nw, k, j, r;
        logic prev;
        void'($urandom(32'd20240611));
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // Reset / disabled state
        chk("R7 reset status", {24'd0, status}, {24'd0, exp_stat(1, 0, 0, 1, 0)});
        chk("R8 reset irq mode0", {31'd0, irq}, 32'd1);
        chk("R1 idle pins", {29'd0, sck_o, ss_n_o, sdo_o}, 32'b010);

        // R1: write while disabled is ignored
        wr_tx(8'h3C);
        en = 1'b1;
        tick(20);
        chk("R1 write ignored while disabled", {24'd0, status}, {24'd0, exp_stat(1, 0, 0, 1, 0)});
        chk("R1 no transfer started", {30'd0, sck_o, ss_n_o}, 32'b01);

        // R2: directed master word, timing and bit order
        wr_tx(8'hA5);
        prev = 1'b0; hi_cnt = 0; rises = 0; got = 8'h00;
        for (int c = 0; c < 200; c++) begin
            tick(1);
            if (sck_o && !prev) begin
                if (rises < 8) got[7 - rises] = sdo_o;
                chk("R2 select low at rising sck", {31'd0, ss_n_o}, 32'd0);
                rises++;
            end
            if (sck_o && rises == 1) hi_cnt++;
            prev = sck_o;
        end
        chk("R2 rising edge count", 32'(rises), 32'd8);
        chk("R2 high phase length", 32'(hi_cnt), 32'(DIV));
        chk("R2 MSB-first data", {24'd0, got}, 32'hA5);
        chk("R5 idle after word", {31'd0, status[3]}, 32'd1);
        model_push(8'hA5);
        chk("R7 rx not empty", {31'd0, status[5]}, 32'd0);
        rd_rx(d);
        void'(rxq.pop_front());
        chk("R2 loopback word", {24'd0, d}, 32'hA5);

        // Slave: overfill TX, five-word frame, overflow
        master = 1'b0;
        tick(2);
        for (int i = 0; i < 5; i++) wr_tx(8'h11 * (i + 1));
        chk("R9 TX full after extra write", {24'd0, status}, {24'd0, exp_stat(0, 4, 0, 1, 0)});
        check_irq_all(4, 0, 1);
        for (int i = 0; i < 5; i++) mo_a[i] = 8'hC0 + 8'(i);
        slv_frame(5);
        for (int i = 0; i < 4; i++)
            chk("R3 slave shifted word", {24'd0, mi_a[i]}, 32'(8'h11 * (i + 1)));
        chk("R3 empty TX sends zero / R9 fifth write dropped", {24'd0, mi_a[4]}, 32'd0);
        for (int i = 0; i < 5; i++) model_push(mo_a[i]);
        chk("R6 overflow set / R4 slave count", {24'd0, status}, {24'd0, exp_stat(0, 0, 4, 1, 1)});
        check_irq_all(0, 4, 1);
        for (int i = 0; i < 4; i++) begin
            rd_rx(d);
            chk("R6 discarded word not kept", {24'd0, d}, {24'd0, rxq.pop_front()});
        end
        chk("R6 flag holds after reads", {31'd0, status[4]}, 32'd1);
        ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0; ovf_m = 1'b0;
        chk("R6 flag cleared", {31'd0, status[4]}, 32'd0);

        // R9: read from empty RX has no effect
        rd_rx(d);
        chk("R9 empty read ignored", {24'd0, status}, {24'd0, exp_stat(0, 0, 0, 1, 0)});
        mo_a[0] = 8'h5A;
        slv_frame(1);
        rd_rx(d);
        chk("R9 next word intact", {24'd0, d}, 32'h5A);

        // R1: disabling flushes both FIFOs
        wr_tx(8'h77); wr_tx(8'h78);
        mo_a[0] = 8'h99;
        ss_n_i = 1'b1;
        en = 1'b0;
        tick(2);
        chk("R1 FIFOs flushed", {24'd0, status}, {24'd0, exp_stat(0, 0, 0, 1, 0)});
        master = 1'b1;
        chk("R1 flushed TX in master view", {29'd0, status[2:0]}, 32'd0);
        en = 1'b1;
        tick(2);

        // Random mix
        for (int it = 0; it < 40; it++) begin
            if ($urandom % 2 == 0) begin
                master = 1'b1;
                nw = 1 + int'($urandom % 4);
                for (int i = 0; i < nw; i++) begin
                    txw[i] = 8'($urandom);
                    wr_tx(txw[i]);
                end
                wait_idle();
                for (int i = 0; i < nw; i++) model_push(txw[i]);
                chk("R4 master status", {24'd0, status},
                    {24'd0, exp_stat(1, 0, rxq.size(), 1, ovf_m)});
                check_irq_all(0, rxq.size(), 1);
            end else begin
                master = 1'b0;
                tick(2);
                k = int'($urandom % 5);
                for (int i = 0; i < k; i++) begin
                    txw[i] = 8'($urandom);
                    wr_tx(txw[i]);
                end
                chk("R4 slave status before frame", {24'd0, status},
                    {24'd0, exp_stat(0, k, rxq.size(), 1, ovf_m)});
                check_irq_all(k, rxq.size(), 1);
                j = ((k > 0) ? k : 1) + int'($urandom % 2);
                if (j > 5) j = 5;
                for (int i = 0; i < j; i++) mo_a[i] = 8'($urandom);
                slv_frame(j);
                for (int i = 0; i < j; i++) begin
                    chk("R3 slave output word", {24'd0, mi_a[i]}, {24'd0, (i < k) ? txw[i] : 8'h00});
                    model_push(mo_a[i]);
                end
                chk("R7 slave status after frame", {24'd0, status},
                    {24'd0, exp_stat(0, 0, rxq.size(), 1, ovf_m)});
            end
            r = int'($urandom % (rxq.size() + 1));
            for (int i = 0; i < r; i++) begin
                rd_rx(d);
                chk("R9 read oldest word", {24'd0, d}, {24'd0, rxq.pop_front()});
            end
            if ($urandom % 3 == 0) begin
                ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0; ovf_m = 1'b0;
                chk("R6 clear strobe", {31'd0, status[4]}, 32'd0);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule